// File: doc/BRIEF.md
# Interrupt status and mask controller

This block collects event pulses from the six channel engines of a DMA unit into two sticky 32-bit status words. One word holds normal events: descriptor completion, data-fetch failure and vertical sync. The other holds errors: descriptor read failure, bad preamble, checksum mismatch and re-use of a completed descriptor. Each event sets a fixed bit that depends on its kind and its channel. Software clears status bits by writing ones to them.

Each status word has its own mask. Software never writes a mask directly. It changes a mask through two strobe registers: one clears mask bits (unmask) and the other sets them (mask). The block drives a single level-sensitive interrupt line, which is high whenever a status bit in either word is set while its mask bit is clear. Register writes come over a plain 32-bit write port. Reads are combinational from a separate read address.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, both status words read 0, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF and `irq` is low.
- R2: A write to a status word clears every bit that is 1 in the written data and leaves the other bits unchanged (write-one-to-clear).
- R3: A write to an unmask strobe clears the mask bits that are 1 in the data. A write to a mask strobe sets them. The new mask can be read after the write edge.
- R4: A write to the address of either mask word leaves both masks unchanged.
- R5: `irq` is registered. It goes high one clock after some status bit in either word is set with its mask bit clear, and it goes low one clock after no such bit remains.
- R6: In the normal word, a completion pulse on channel n sets bit n, a data-fetch failure on channel n sets bit 12+n, and a vertical-sync pulse sets bit 27.
- R7: In the error word, for channel n: a descriptor read failure sets bit 1+n, a bad preamble sets bit 7+n, a checksum mismatch sets bit 13+n and a completed-descriptor error sets bit 25+n.
- R8: When an event and a write-one-to-clear hit the same bit on the same clock, the bit ends up set.
- R9: A status bit stays set until software clears it, even after its event input has returned low.
- R10: Word addresses: 0 normal status, 1 error status, 2 normal mask, 3 error mask, 4 normal unmask strobe, 5 normal mask strobe, 6 error unmask strobe, 7 error mask strobe. The four strobe addresses read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address for a write |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register word address for a read |
| rd_data | output | DW | Read data, combinational from rd_addr |
| evt_done | input | NCH | Descriptor completion pulse per channel |
| evt_fetch_fail | input | NCH | Data-fetch failure pulse per channel |
| evt_vsync | input | 1 | Vertical-sync pulse |
| err_desc_rd | input | NCH | Descriptor read failure pulse per channel |
| err_preamble | input | NCH | Bad preamble pulse per channel |
| err_crc | input | NCH | Checksum mismatch pulse per channel |
| err_redone | input | NCH | Already-completed descriptor pulse per channel |
| irq | output | 1 | Level interrupt request |

## Verification
A status or mask change lands on the clock edge that samples the event or the write. It is visible on `rd_data` right after that edge. `irq` follows one edge later. Each table vector therefore drives its stimulus for one edge and then idles for one more edge before it samples both the register and `irq` on the falling edge, so either result is checked where it is due. A directed test drives an unmask write and samples `irq` once after the first edge, where it must still be low, and once after the second edge, where it must be high. This pins the one-cycle latency in both directions.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter logic [DW-1:0] NMASK_RST = 'h07FF_FFFF,
  parameter logic [DW-1:0] EMASK_RST = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] evt_done,
  input  logic [NCH-1:0] evt_fetch_fail,
  input  logic           evt_vsync,
  input  logic [NCH-1:0] err_desc_rd,
  input  logic [NCH-1:0] err_preamble,
  input  logic [NCH-1:0] err_crc,
  input  logic [NCH-1:0] err_redone,
  output logic           irq
);
  localparam int DONE_LSB   = 0;
  localparam int FFAIL_LSB  = 12;
  localparam int VSYNC_BIT  = 27;
  localparam int DRD_LSB    = 1;
  localparam int PRE_LSB    = 7;
  localparam int CRC_LSB    = 13;
  localparam int REDONE_LSB = 25;

  localparam logic [AW-1:0] A_NSTAT  = AW'(0);
  localparam logic [AW-1:0] A_ESTAT  = AW'(1);
  localparam logic [AW-1:0] A_NMASK  = AW'(2);
  localparam logic [AW-1:0] A_EMASK  = AW'(3);
  localparam logic [AW-1:0] A_NUNMSK = AW'(4);
  localparam logic [AW-1:0] A_NSETMK = AW'(5);
  localparam logic [AW-1:0] A_EUNMSK = AW'(6);
  localparam logic [AW-1:0] A_ESETMK = AW'(7);

  logic [DW-1:0] nstat, estat, nmask, emask;
  logic [DW-1:0] nset, eset;

  always_comb begin
    nset = '0;
    eset = '0;
    for (int i = 0; i < NCH; i++) begin
      nset[DONE_LSB + i]   = evt_done[i];
      nset[FFAIL_LSB + i]  = evt_fetch_fail[i];
      eset[DRD_LSB + i]    = err_desc_rd[i];
      eset[PRE_LSB + i]    = err_preamble[i];
      eset[CRC_LSB + i]    = err_crc[i];
      eset[REDONE_LSB + i] = err_redone[i];
    end
    nset[VSYNC_BIT] = evt_vsync;
  end

  wire hit_nstat  = wr_en && wr_addr == A_NSTAT;
  wire hit_estat  = wr_en && wr_addr == A_ESTAT;
  wire hit_nunmsk = wr_en && wr_addr == A_NUNMSK;
  wire hit_nsetmk = wr_en && wr_addr == A_NSETMK;
  wire hit_eunmsk = wr_en && wr_addr == A_EUNMSK;
  wire hit_esetmk = wr_en && wr_addr == A_ESETMK;

  wire [DW-1:0] nclr = hit_nstat ? wr_data : '0;
  wire [DW-1:0] eclr = hit_estat ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nstat <= '0;
      estat <= '0;
      nmask <= NMASK_RST;
      emask <= EMASK_RST;
      irq   <= 1'b0;
    end else begin
      nstat <= (nstat & ~nclr) | nset;
      estat <= (estat & ~eclr) | eset;
      if (hit_nunmsk)      nmask <= nmask & ~wr_data;
      else if (hit_nsetmk) nmask <= nmask | wr_data;
      if (hit_eunmsk)      emask <= emask & ~wr_data;
      else if (hit_esetmk) emask <= emask | wr_data;
      irq <= |(nstat & ~nmask) || |(estat & ~emask);
    end
  end

  always_comb begin
    case (rd_addr)
      A_NSTAT: rd_data = nstat;
      A_ESTAT: rd_data = estat;
      A_NMASK: rd_data = nmask;
      A_EMASK: rd_data = emask;
      default: rd_data = '0;
    endcase
  end

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_nstat && evt_done == '0 && evt_fetch_fail == '0 && !evt_vsync)
    |=> (nstat & $past(wr_data)) == '0);

  p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_eunmsk |=> (emask & $past(wr_data)) == '0);

  p_setmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_nsetmk |=> (nmask & $past(wr_data)) == $past(wr_data));

  p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_NMASK || wr_addr == A_EMASK))
    |=> ($stable(nmask) && $stable(emask)));

  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nstat == '0 && estat == '0) |-> !irq);

  p_done_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done != '0 |=> (nstat[DONE_LSB +: NCH] & $past(evt_done)) == $past(evt_done));

  p_redone_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_redone != '0 |=> (estat[REDONE_LSB +: NCH] & $past(err_redone)) == $past(err_redone));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_nstat && evt_vsync) |=> nstat[VSYNC_BIT]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_estat |=> (estat & $past(estat)) == $past(estat));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  evt_done = '0, evt_fetch_fail = '0;
  logic        evt_vsync = 1'b0;
  logic [5:0]  err_desc_rd = '0, err_preamble = '0, err_crc = '0, err_redone = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_done(evt_done),
    .evt_fetch_fail(evt_fetch_fail), .evt_vsync(evt_vsync), .err_desc_rd(err_desc_rd),
    .err_preamble(err_preamble), .err_crc(err_crc), .err_redone(err_redone), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [5:0]  dd, df;
    logic        vs;
    logic [5:0]  ef, ep, ec, ed;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic        xirq;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 3'd0, 32'h0,        6'h01, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0000_0001, 1'b0, " R6"},
    '{1'b1, 3'd4, 32'h1,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd2, 32'h07FF_FFFE, 1'b1, " R3"},
    '{1'b1, 3'd0, 32'h1,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0000_0000, 1'b0, " R2"},
    '{1'b0, 3'd0, 32'h0,        6'h00, 6'h20, 1'b1, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0802_0000, 1'b1, " R6"},
    '{1'b1, 3'd0, 32'h0800_0000,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0002_0000, 1'b0, " R2"},
    '{1'b1, 3'd2, 32'h0,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd2, 32'h07FF_FFFE, 1'b0, " R4"},
    '{1'b1, 3'd5, 32'hFFFF_FFFF,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd2, 32'hFFFF_FFFF, 1'b0, " R3"},
    '{1'b1, 3'd0, 32'h0002_0000,6'h00, 6'h20, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0002_0000, 1'b0, " R8"},
    '{1'b1, 3'd0, 32'h0002_0000,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0000_0000, 1'b0, " R2"},
    '{1'b0, 3'd0, 32'h0,        6'h00, 6'h00, 1'b0, 6'h04, 6'h01, 6'h20, 6'h02, 3'd1, 32'h0404_0088, 1'b0, " R7"},
    '{1'b1, 3'd6, 32'h0004_0000,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd3, 32'hFFFB_FFFF, 1'b1, " R5"},
    '{1'b1, 3'd3, 32'h0,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd3, 32'hFFFB_FFFF, 1'b1, " R4"},
    '{1'b1, 3'd1, 32'hFFFF_FFFF,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd1, 32'h0000_0000, 1'b0, " R2"},
    '{1'b1, 3'd7, 32'h0004_0000,6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd6, 32'h0000_0000, 1'b0, "R10"},
    '{1'b0, 3'd0, 32'h0,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h01, 6'h20, 3'd1, 32'h4000_2000, 1'b0, " R7"},
    '{1'b0, 3'd0, 32'h0,        6'h20, 6'h00, 1'b0, 6'h01, 6'h00, 6'h00, 6'h00, 3'd1, 32'h4000_2002, 1'b0, " R7"},
    '{1'b0, 3'd0, 32'h0,        6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'h00, 6'h00, 3'd0, 32'h0000_0020, 1'b0, " R9"}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    evt_done = '0; evt_fetch_fail = '0; evt_vsync = 1'b0;
    err_desc_rd = '0; err_preamble = '0; err_crc = '0; err_redone = '0;
  endtask

  task automatic read_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 and R10: reset values and zero readback of strobe addresses
    read_check("R1 nstat", 3'd0, 32'h0);
    read_check("R1 estat", 3'd1, 32'h0);
    read_check("R1 nmask", 3'd2, 32'h07FF_FFFF);
    read_check("R1 emask", 3'd3, 32'hFFFF_FFFF);
    read_check("R10 s4", 3'd4, 32'h0);
    read_check("R10 s5", 3'd5, 32'h0);
    read_check("R10 s6", 3'd6, 32'h0);
    read_check("R10 s7", 3'd7, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en = VECS[k].we; wr_addr = VECS[k].wa; wr_data = VECS[k].wd;
      evt_done = VECS[k].dd; evt_fetch_fail = VECS[k].df; evt_vsync = VECS[k].vs;
      err_desc_rd = VECS[k].ef; err_preamble = VECS[k].ep;
      err_crc = VECS[k].ec; err_redone = VECS[k].ed;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      read_check($sformatf("%s reg v%0d", VECS[k].tag, k), VECS[k].ra, VECS[k].exp);
      check($sformatf("%s irq v%0d", VECS[k].tag, k), {31'b0, irq}, {31'b0, VECS[k].xirq});
    end

    // R5: interrupt latency, unmask normal bit 5 which is pending
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h20;
    @(negedge clk);
    idle_inputs();
    check("R5 irq first edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R5 irq second edge", {31'b0, irq}, 32'h1);
    // R5: falling latency after clearing the bit
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h20;
    @(negedge clk);
    idle_inputs();
    check("R5 irq held", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R5 irq drop", {31'b0, irq}, 32'h0);

    // R1: reset in mid-run restores masks and clears status
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    read_check("R1 estat again", 3'd1, 32'h0);
    read_check("R1 nmask again", 3'd2, 32'h07FF_FFFF);
    check("R1 irq again", {31'b0, irq}, 32'h0);
    summary();
  end
endmodule